// File: doc/BRIEF.md
# Adaptive Iterative Block-Matching Motion Estimator

This block finds the motion of one 8x8 pixel block across one video-rate frame period. It does this in a series of short searches, one for each high-speed intermediate picture of the period. Every search compares the current block against a single reference search area that stays loaded for the whole period. Each search is centred on the vector that the previous search returned. The search window on each axis is then widened toward the direction in which the previous search moved. After the last intermediate picture, the vector on the outputs is the video-rate motion vector.

Pixels enter through one write port. A select input chooses between the block buffer and the reference buffer. A `start` pulse runs one search. A `clr` input, sampled while the block is idle, begins a new period. When a search completes, the block updates the best vector and its sum of absolute differences (SAD), and raises `done` for one cycle.

The controller is a state machine with seven states:
- IDLE waits for `start`. It also applies `clr`.
- LOAD latches the centre and the first candidate offset.
- CHECK tests whether the candidate lies inside the search area. It goes to ACC if it does, and to STEP if it does not.
- ACC adds one row SAD per cycle, for 8 cycles, and then goes to CMP.
- CMP keeps the candidate if it is a strict improvement. It then goes to STEP.
- STEP advances the raster position. It goes back to CHECK, or to DONE after the last candidate.
- DONE saturates and publishes the result, updates the ranges, and returns to IDLE.

Top module: `ame_core`

## Requirements
- R1: After reset, `done` is low and `mv_x`, `mv_y` and `min_sad` are zero.
- R2: The first search after a clear tries offsets from -P to +P on both axes around vector zero, with P = 2. A true motion outside that window is not reached.
- R3: A later search is centred on the previous result. On an axis whose previous step was positive, the offsets run from -P to +2P.
- R4: On an axis whose previous step was negative, the offsets run from -2P to +P.
- R5: A zero step on an axis leaves that axis's range as it was before.
- R6: The cost of a candidate is the sum of absolute differences over 8x8 unsigned 8-bit pixels. `min_sad` reports the cost of the chosen candidate, which is 0 for an exact match.
- R7: Candidates are visited with the vertical offset in the outer loop and the horizontal offset in the inner loop, both ascending. Only a strictly smaller cost replaces the current best, so the first of several equal candidates wins.
- R8: A candidate is skipped when its absolute vector on either axis exceeds (SA-8)/2 = 17, with SA = 42. Such a candidate would read outside the reference area.
- R9: Each component of the result saturates at ±15. The saturated vector becomes the centre of the next search.
- R10: `done` is high for exactly one cycle per search. The outputs change only in that cycle. A `start` that arrives while a search is running is ignored.
- R11: `clr` in IDLE resets the stored vector to zero and both ranges to symmetric. When `clr` and `start` arrive in the same cycle, the search uses the cleared state.
- R12: With `wr_ref`=1, `wr_addr` = row*42+col writes the reference pixel. With `wr_ref`=0, `wr_addr` = row*8+col writes the block pixel. Reference row/col zero is the vector (-17,-17).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clr | input | 1 | New-period clear, sampled in IDLE |
| start | input | 1 | Begin one search |
| wr_en | input | 1 | Pixel write strobe |
| wr_ref | input | 1 | 1 selects reference buffer, 0 the block buffer |
| wr_addr | input | 11 | Pixel address (row*width+col) |
| wr_data | input | 8 | Pixel value |
| mv_x | output | 6 | Signed horizontal vector |
| mv_y | output | 6 | Signed vertical vector |
| min_sad | output | 14 | SAD of the chosen candidate |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest conditions to reach are saturation and the skipping of candidates outside the area. A single search cannot produce either, because the centre must first be walked toward the edge of the area. The bench uses a texture that is a pure horizontal ramp, so the cost falls steadily toward the true position. It places the block 17 columns to the right, and then chains six searches. Each search takes the widened window further, until candidates past the area edge are skipped and the result clips at 15. Because the ramp has no vertical structure, every row ties. The vertical component therefore follows the first-found rule downward and reaches the same edge and the same clipping on the other axis.

// File: rtl/ame_pkg.sv
package ame_pkg;

    typedef enum logic [1:0] {
        RNG_EVEN = 2'd0,
        RNG_FWD  = 2'd1,
        RNG_BACK = 2'd2
    } rng_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_LOAD  = 3'd1,
        ST_CHECK = 3'd2,
        ST_ACC   = 3'd3,
        ST_CMP   = 3'd4,
        ST_STEP  = 3'd5,
        ST_DONE  = 3'd6
    } me_state_e;

endpackage

// File: rtl/ame_axis_range.sv
module ame_axis_range
    import ame_pkg::*;
#(
    parameter int P  = 2,
    parameter int VW = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr_now,
    input  logic                 upd,
    input  logic signed [VW-1:0] step,
    output logic signed [VW-1:0] lo,
    output logic signed [VW-1:0] hi
);

    rng_mode_e mode_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= RNG_EVEN;
        end else if (clr_now) begin
            mode_q <= RNG_EVEN;
        end else if (upd) begin
            if (step > 0) begin
                mode_q <= RNG_FWD;
            end else if (step < 0) begin
                mode_q <= RNG_BACK;
            end
        end
    end

    always_comb begin
        unique case (mode_q)
            RNG_FWD: begin
                lo = VW'(-P);
                hi = VW'(2 * P);
            end
            RNG_BACK: begin
                lo = VW'(-2 * P);
                hi = VW'(P);
            end
            default: begin
                lo = VW'(-P);
                hi = VW'(P);
            end
        endcase
    end

endmodule

// File: rtl/ame_pix_store.sv
module ame_pix_store #(
    parameter int BLK  = 8,
    parameter int PIXW = 8,
    parameter int SA   = 42,
    parameter int AW   = 11,
    parameter int RW   = 3,
    parameter int CW   = 6
) (
    input  logic                  clk,
    input  logic                  we,
    input  logic                  sel_ref,
    input  logic [AW-1:0]         waddr,
    input  logic [PIXW-1:0]       wdata,
    input  logic [RW-1:0]         row,
    input  logic [CW-1:0]         org_r,
    input  logic [CW-1:0]         org_c,
    output logic [BLK*PIXW-1:0]   blk_row,
    output logic [BLK*PIXW-1:0]   ref_row
);

    localparam int BN = BLK * BLK;
    localparam int RN = SA * SA;
    localparam int BA = $clog2(BN);
    localparam int RA = $clog2(RN);

    logic [PIXW-1:0] blk_mem [BN];
    logic [PIXW-1:0] ref_mem [RN];

    always_ff @(posedge clk) begin
        if (we) begin
            if (sel_ref) begin
                if (int'(waddr) < RN) begin
                    ref_mem[RA'(waddr)] <= wdata;
                end
            end else if (int'(waddr) < BN) begin
                blk_mem[BA'(waddr)] <= wdata;
            end
        end
    end

    for (genvar k = 0; k < BLK; k++) begin : g_lane
        int bi;
        int ri;
        always_comb begin
            bi = int'(row) * BLK + k;
            ri = (int'(org_r) + int'(row)) * SA + int'(org_c) + k;
            blk_row[k*PIXW +: PIXW] = (bi < BN) ? blk_mem[BA'(bi)] : '0;
            ref_row[k*PIXW +: PIXW] = (ri < RN) ? ref_mem[RA'(ri)] : '0;
        end
    end

endmodule

// File: rtl/ame_row_sad.sv
module ame_row_sad #(
    parameter int BLK  = 8,
    parameter int PIXW = 8,
    parameter int RSW  = 11
) (
    input  logic [BLK*PIXW-1:0] a_row,
    input  logic [BLK*PIXW-1:0] b_row,
    output logic [RSW-1:0]      row_sad
);

    logic [PIXW-1:0] adiff [BLK];

    for (genvar k = 0; k < BLK; k++) begin : g_abs
        logic [PIXW-1:0] pa;
        logic [PIXW-1:0] pb;
        assign pa = a_row[k*PIXW +: PIXW];
        assign pb = b_row[k*PIXW +: PIXW];
        assign adiff[k] = (pa >= pb) ? (pa - pb) : (pb - pa);
    end

    always_comb begin
        row_sad = '0;
        for (int k = 0; k < BLK; k++) begin
            row_sad = row_sad + RSW'(adiff[k]);
        end
    end

endmodule

// File: rtl/ame_core.sv
module ame_core
    import ame_pkg::*;
#(
    parameter int BLK  = 8,
    parameter int PIXW = 8,
    parameter int P    = 2,
    parameter int VMAX = 15,
    parameter int SA   = 42,
    localparam int AW   = $clog2(SA * SA),
    localparam int VW   = $clog2(VMAX + 2 * P + 1) + 1,
    localparam int SADW = PIXW + 2 * $clog2(BLK)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clr,
    input  logic                   start,
    input  logic                   wr_en,
    input  logic                   wr_ref,
    input  logic [AW-1:0]          wr_addr,
    input  logic [PIXW-1:0]        wr_data,
    output logic signed [VW-1:0]   mv_x,
    output logic signed [VW-1:0]   mv_y,
    output logic [SADW-1:0]        min_sad,
    output logic                   done
);

    localparam int ORG  = (SA - BLK) / 2;
    localparam int RW   = $clog2(BLK);
    localparam int CW   = $clog2(SA);
    localparam int RSW  = PIXW + $clog2(BLK);

    me_state_e state_q, state_d;

    logic signed [VW-1:0] px_q, py_q;
    logic signed [VW-1:0] cx_q, cy_q;
    logic signed [VW-1:0] dx_q, dy_q;
    logic signed [VW-1:0] bdx_q, bdy_q;
    logic [RW-1:0]        row_q;
    logic [SADW-1:0]      acc_q, best_q;
    logic                 found_q;

    logic signed [VW-1:0] lo_x, hi_x, lo_y, hi_y;
    logic signed [VW-1:0] step_x, step_y;
    logic signed [VW-1:0] sat_x, sat_y;
    logic                 clr_now, upd;
    logic                 cand_ok, last_cand, last_row;
    int                   pos_x, pos_y, raw_x, raw_y;
    logic [CW-1:0]        org_r, org_c;
    logic [BLK*PIXW-1:0]  blk_row, ref_row;
    logic [RSW-1:0]       row_sad;

    assign clr_now = (state_q == ST_IDLE) && clr;
    assign upd     = (state_q == ST_DONE);
    assign step_x  = found_q ? bdx_q : '0;
    assign step_y  = found_q ? bdy_q : '0;

    ame_axis_range #(.P(P), .VW(VW)) u_rng_x (
        .clk(clk), .rst_n(rst_n), .clr_now(clr_now), .upd(upd),
        .step(step_x), .lo(lo_x), .hi(hi_x)
    );

    ame_axis_range #(.P(P), .VW(VW)) u_rng_y (
        .clk(clk), .rst_n(rst_n), .clr_now(clr_now), .upd(upd),
        .step(step_y), .lo(lo_y), .hi(hi_y)
    );

    always_comb begin
        pos_x     = ORG + int'(cx_q) + int'(dx_q);
        pos_y     = ORG + int'(cy_q) + int'(dy_q);
        cand_ok   = (pos_x >= 0) && (pos_x <= SA - BLK) &&
                    (pos_y >= 0) && (pos_y <= SA - BLK);
        org_c     = CW'(pos_x);
        org_r     = CW'(pos_y);
        last_cand = (dx_q == hi_x) && (dy_q == hi_y);
        last_row  = (row_q == RW'(BLK - 1));
    end

    ame_pix_store #(
        .BLK(BLK), .PIXW(PIXW), .SA(SA), .AW(AW), .RW(RW), .CW(CW)
    ) u_store (
        .clk(clk), .we(wr_en), .sel_ref(wr_ref), .waddr(wr_addr),
        .wdata(wr_data), .row(row_q), .org_r(org_r), .org_c(org_c),
        .blk_row(blk_row), .ref_row(ref_row)
    );

    ame_row_sad #(.BLK(BLK), .PIXW(PIXW), .RSW(RSW)) u_rsad (
        .a_row(blk_row), .b_row(ref_row), .row_sad(row_sad)
    );

    always_comb begin
        raw_x = int'(cx_q) + (found_q ? int'(bdx_q) : 0);
        raw_y = int'(cy_q) + (found_q ? int'(bdy_q) : 0);
        if (raw_x > VMAX) begin
            sat_x = VW'(VMAX);
        end else if (raw_x < -VMAX) begin
            sat_x = VW'(-VMAX);
        end else begin
            sat_x = VW'(raw_x);
        end
        if (raw_y > VMAX) begin
            sat_y = VW'(VMAX);
        end else if (raw_y < -VMAX) begin
            sat_y = VW'(-VMAX);
        end else begin
            sat_y = VW'(raw_y);
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = ST_LOAD;
            ST_LOAD:  state_d = ST_CHECK;
            ST_CHECK: state_d = cand_ok ? ST_ACC : ST_STEP;
            ST_ACC:   if (last_row) state_d = ST_CMP;
            ST_CMP:   state_d = ST_STEP;
            ST_STEP:  state_d = last_cand ? ST_DONE : ST_CHECK;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // search datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            px_q    <= '0;
            py_q    <= '0;
            cx_q    <= '0;
            cy_q    <= '0;
            dx_q    <= '0;
            dy_q    <= '0;
            bdx_q   <= '0;
            bdy_q   <= '0;
            row_q   <= '0;
            acc_q   <= '0;
            best_q  <= '1;
            found_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (clr) begin
                        px_q <= '0;
                        py_q <= '0;
                    end
                end
                ST_LOAD: begin
                    cx_q    <= px_q;
                    cy_q    <= py_q;
                    dx_q    <= lo_x;
                    dy_q    <= lo_y;
                    best_q  <= '1;
                    found_q <= 1'b0;
                end
                ST_CHECK: begin
                    row_q <= '0;
                    acc_q <= '0;
                end
                ST_ACC: begin
                    acc_q <= acc_q + SADW'(row_sad);
                    row_q <= row_q + RW'(1);
                end
                ST_CMP: begin
                    if (!found_q || (acc_q < best_q)) begin
                        best_q  <= acc_q;
                        bdx_q   <= dx_q;
                        bdy_q   <= dy_q;
                        found_q <= 1'b1;
                    end
                end
                ST_STEP: begin
                    if (dx_q == hi_x) begin
                        dx_q <= lo_x;
                        dy_q <= dy_q + VW'(1);
                    end else begin
                        dx_q <= dx_q + VW'(1);
                    end
                end
                ST_DONE: begin
                    px_q <= sat_x;
                    py_q <= sat_y;
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done    <= 1'b0;
            mv_x    <= '0;
            mv_y    <= '0;
            min_sad <= '0;
        end else begin
            done <= (state_q == ST_DONE);
            if (state_q == ST_DONE) begin
                mv_x    <= sat_x;
                mv_y    <= sat_y;
                min_sad <= found_q ? best_q : '1;
            end
        end
    end

endmodule

// File: rtl/ame_core_chk.sv
module ame_core_chk #(
    parameter int VMAX = 15,
    parameter int ORG  = 17,
    parameter int VW   = 6,
    parameter int SADW = 14
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 done,
    input logic signed [VW-1:0] mv_x,
    input logic signed [VW-1:0] mv_y,
    input logic [SADW-1:0]      min_sad,
    input logic                 in_acc,
    input logic signed [VW-1:0] cx,
    input logic signed [VW-1:0] cy,
    input logic signed [VW-1:0] dx,
    input logic signed [VW-1:0] dy,
    input logic signed [VW-1:0] lo_x,
    input logic signed [VW-1:0] hi_x,
    input logic signed [VW-1:0] lo_y,
    input logic signed [VW-1:0] hi_y
);

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(mv_x) && $stable(mv_y) && $stable(min_sad)));

    // R9
    mv_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(mv_x) <= VMAX) && (int'(mv_x) >= -VMAX) &&
        (int'(mv_y) <= VMAX) && (int'(mv_y) >= -VMAX));

    // R3 R4
    window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_acc |-> (dx >= lo_x) && (dx <= hi_x) && (dy >= lo_y) && (dy <= hi_y));

    // R8
    inside_area_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_acc |-> (int'(cx) + int'(dx) <= ORG) && (int'(cx) + int'(dx) >= -ORG) &&
                   (int'(cy) + int'(dy) <= ORG) && (int'(cy) + int'(dy) >= -ORG));

endmodule

bind ame_core ame_core_chk #(.VMAX(VMAX), .ORG(ORG), .VW(VW), .SADW(SADW)) u_chk (
    .clk(clk), .rst_n(rst_n), .done(done), .mv_x(mv_x), .mv_y(mv_y),
    .min_sad(min_sad), .in_acc(state_q == ame_pkg::ST_ACC),
    .cx(cx_q), .cy(cy_q), .dx(dx_q), .dy(dy_q),
    .lo_x(lo_x), .hi_x(hi_x), .lo_y(lo_y), .hi_y(hi_y)
);

// File: tb/ame_core_test.sv
module ame_core_test;

    localparam int SA   = 42;
    localparam int BLK  = 8;
    localparam int ORG  = 17;
    localparam int AW   = 11;
    localparam int VW   = 6;
    localparam int SADW = 14;

    // {clr, tx, ty, exp_x, exp_y, exp_sad}; horizontal-ramp texture
    localparam logic [48:0] WALK [6] = '{
        {1'b1, 8'd17, 8'd0, 8'd2,  8'hFE, 16'd5760},
        {1'b0, 8'd17, 8'd0, 8'd6,  8'hFA, 16'd4224},
        {1'b0, 8'd17, 8'd0, 8'd10, 8'hF6, 16'd2688},
        {1'b0, 8'd17, 8'd0, 8'd14, 8'hF2, 16'd1152},
        {1'b0, 8'd17, 8'd0, 8'd15, 8'hF1, 16'd0},
        {1'b0, 8'd17, 8'd0, 8'd15, 8'hF1, 16'd0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clr = 1'b0;
    logic start = 1'b0;
    logic wr_en = 1'b0;
    logic wr_ref = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic signed [VW-1:0] mv_x, mv_y;
    logic [SADW-1:0] min_sad;
    logic done;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    ame_core uut (
        .clk(clk), .rst_n(rst_n), .clr(clr), .start(start),
        .wr_en(wr_en), .wr_ref(wr_ref), .wr_addr(wr_addr), .wr_data(wr_data),
        .mv_x(mv_x), .mv_y(mv_y), .min_sad(min_sad), .done(done)
    );

    function automatic logic [7:0] tex(input int sel, input int r, input int c);
        if (sel == 0) return 8'(6 * c);
        return 8'((29 * r + 13 * c + 7 * r * c) & 255);
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic load_ref(input int sel);
        for (int r = 0; r < SA; r++) begin
            for (int c = 0; c < SA; c++) begin
                @(negedge clk);
                wr_en = 1'b1; wr_ref = 1'b1;
                wr_addr = AW'(r * SA + c); wr_data = tex(sel, r, c);
            end
        end
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic load_blk(input int sel, input int tx, input int ty);
        for (int r = 0; r < BLK; r++) begin
            for (int c = 0; c < BLK; c++) begin
                @(negedge clk);
                wr_en = 1'b1; wr_ref = 1'b0;
                wr_addr = AW'(r * BLK + c);
                wr_data = tex(sel, ORG + ty + r, ORG + tx + c);
            end
        end
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic run_search(input bit with_clr);
        bit seen = 1'b0;
        @(negedge clk);
        start = 1'b1; clr = with_clr;
        @(negedge clk);
        start = 1'b0; clr = 1'b0;
        for (int i = 0; i < 5000; i++) begin
            if (done) begin
                seen = 1'b1;
                break;
            end
            @(negedge clk);
        end
        chk(seen, "R10 done arrives", int'(seen), 1);
    endtask

    task automatic expect_mv(input string tag, input int ex, input int ey, input int es);
        chk(int'(mv_x) == ex, {tag, " mv_x"}, int'(mv_x), ex);
        chk(int'(mv_y) == ey, {tag, " mv_y"}, int'(mv_y), ey);
        chk(int'(min_sad) == es, {tag, " sad"}, int'(min_sad), es);
    endtask

    initial begin
        while (!finished && cyc < 190000) begin
            @(posedge clk);
            cyc++;
        end
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int dones;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(done == 1'b0, "R1 done", int'(done), 0);
        chk(mv_x == '0 && mv_y == '0, "R1 vector", int'(mv_x), 0);
        chk(min_sad == '0, "R1 sad", int'(min_sad), 0);
        rst_n = 1'b1;

        // table walk: R7 ties on rows, R8 skipped columns/rows, R9 clipping, R3 R4 skew
        load_ref(0);
        for (int i = 0; i < 6; i++) begin
            logic [48:0] e;
            e = WALK[i];
            load_blk(0, int'($signed(e[47:40])), int'($signed(e[39:32])));
            run_search(e[48]);
            expect_mv($sformatf("R7 R8 R9 walk%0d", i), int'($signed(e[31:24])),
                      int'($signed(e[23:16])), int'(e[15:0]));
        end

        // directed, hashed texture
        load_ref(1);
        // R2 R6 R12 exact match within first window
        load_blk(1, 1, -2);
        run_search(1'b1);
        expect_mv("R2 R6 R12 first", 1, -2, 0);

        // R2 true motion outside symmetric window not reached
        load_blk(1, 3, 0);
        run_search(1'b1);
        chk(int'(mv_x) <= 2 && int'(mv_x) >= -2, "R2 bound x", int'(mv_x), 2);
        chk(min_sad != '0, "R2 no match", int'(min_sad), 1);

        // R3 forward skew
        load_blk(1, 2, 2);
        run_search(1'b1);
        expect_mv("R3 setup", 2, 2, 0);
        load_blk(1, 6, 5);
        run_search(1'b0);
        expect_mv("R3 forward", 6, 5, 0);

        // R4 backward skew, R5 zero keeps range
        load_blk(1, -2, -1);
        run_search(1'b1);
        expect_mv("R4 setup", -2, -1, 0);
        load_blk(1, -6, -1);
        run_search(1'b0);
        expect_mv("R4 backward", -6, -1, 0);
        run_search(1'b0);
        expect_mv("R5 hold", -6, -1, 0);
        load_blk(1, -10, -4);
        run_search(1'b0);
        expect_mv("R5 kept range", -10, -4, 0);

        // R11 clr with start in same cycle
        load_blk(1, 1, 1);
        run_search(1'b1);
        expect_mv("R11 clear", 1, 1, 0);

        // R10 one-cycle done, start while busy ignored
        load_blk(1, 0, 0);
        @(negedge clk);
        start = 1'b1; clr = 1'b1;
        @(negedge clk);
        start = 1'b0; clr = 1'b0;
        dones = 0;
        for (int i = 0; i < 1500; i++) begin
            if (i == 6 || i == 40) start = 1'b1;
            else start = 1'b0;
            if (done) dones++;
            @(negedge clk);
        end
        start = 1'b0;
        chk(dones == 1, "R10 single done", dones, 1);
        chk(done == 1'b0, "R10 done low", int'(done), 0);
        expect_mv("R10 result", 0, 0, 0);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule